// File: doc/BRIEF.md
# Multi-Channel Serial Card I/O Address Decoder

This block sits between a 16-bit I/O address bus and a card carrying eight serial channels. The card claims a 64-byte window whose position is set by a 10-bit switch word. Each channel owns eight consecutive byte locations, in channel order from the window start. The block raises exactly one select per bus cycle and passes the low three address bits through as the register offset inside the selected channel.

A mode input lets one shared, read-only status register take over the topmost offset (7) of every channel. With the mode off, that offset reaches the channel's own scratchpad like any other offset. A write at that offset in status mode is flagged on a separate output, so that interrupt logic can see the write. The written value itself has no path into the status register.

All outputs are registered and appear one clock after the address and strobes are sampled.

Top module: `ioport_decoder`

## Requirements
- R1: The card responds only when address bits [15:6] equal the bitwise complement of `sw_i`. A switch bit of 1 means the switch is on and requires a 0 on that address line. A switch bit of 0 means off and requires a 1. With no match, every select output stays 0.
- R2: On a match, address bits [5:3] give the channel number n, and `ch_sel_o[n]` is the only select raised. Channel n covers window offsets 8n to 8n+7, except offset 7 while status mode is on.
- R3: `reg_off_o` equals address bits [2:0] as sampled on the previous clock edge.
- R4: With `stat_en_i` = 1, a matching access whose address bits [2:0] are 7 raises `stat_sel_o` for any channel number and raises no `ch_sel_o` bit.
- R5: With `stat_en_i` = 0, offset 7 selects the channel like every other offset, and `stat_sel_o` never asserts.
- R6: At most one of the nine select outputs is high at a time. None is high unless `rd_i` or `wr_i` was high in the sampled cycle.
- R7: `stat_wr_o` is high exactly when `stat_sel_o` is high and `wr_i` was high. A status read leaves it at 0.
- R8: While `rst_ni` is low, all outputs are 0.
- R9: Each output reflects the inputs sampled on the preceding rising clock edge, which is a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | I/O address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| sw_i | input | 10 | Base switch word, 1 = switch on (address bit must be 0) |
| stat_en_i | input | 1 | 1 = offset 7 maps to the shared status register |
| ch_sel_o | output | 8 | One-hot channel select |
| stat_sel_o | output | 1 | Shared status register select |
| stat_wr_o | output | 1 | Write flag for the status register |
| reg_off_o | output | 3 | Register offset inside the channel |

## Verification
The hardest situation to reach is a near miss. In that case the address differs from the configured base in exactly one upper bit while the low bits point at a valid register. A decoder that ignores one switch position still looks correct for any sweep done at a single base. The bench therefore runs full sweeps under several switch words, including all-on and all-off. Under each word it flips every upper address bit in turn, and it repeats each offset-7 access with the mode both on and off.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CHAN = 2'd1,
    TGT_STAT = 2'd2
  } iodec_tgt_e;
endpackage

// File: rtl/iodec_base_match.sv
module iodec_base_match #(
  parameter int unsigned HI_W = 10
) (
  input  logic [HI_W-1:0] addr_hi_i,
  input  logic [HI_W-1:0] sw_i,
  output logic            hit_o
);
  // switch on (1) demands address 0
  assign hit_o = (addr_hi_i == ~sw_i);
endmodule

// File: rtl/iodec_target.sv
module iodec_target
  import iodec_pkg::*;
#(
  parameter int unsigned REG_W = 3
) (
  input  logic             hit_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             stat_en_i,
  input  logic [REG_W-1:0] off_i,
  output iodec_tgt_e       tgt_o
);
  localparam logic [REG_W-1:0] StatOff = {REG_W{1'b1}};

  always_comb begin
    tgt_o = TGT_NONE;
    if (hit_i && (rd_i || wr_i)) begin
      if (stat_en_i && off_i == StatOff) tgt_o = TGT_STAT;
      else                               tgt_o = TGT_CHAN;
    end
  end
endmodule

// File: rtl/iodec_onehot.sv
module iodec_onehot #(
  parameter int unsigned IDX_W = 3,
  localparam int unsigned N    = 1 << IDX_W
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             en_i,
  output logic [N-1:0]     sel_o
);
  for (genvar g = 0; g < N; g++) begin : g_sel
    assign sel_o[g] = en_i && (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/ioport_decoder.sv
module ioport_decoder
  import iodec_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned REG_W  = 3,
  localparam int unsigned LOW_W = CH_W + REG_W,
  localparam int unsigned SW_W  = ADDR_W - LOW_W,
  localparam int unsigned N_CH  = 1 << CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [SW_W-1:0]   sw_i,
  input  logic              stat_en_i,
  output logic [N_CH-1:0]   ch_sel_o,
  output logic              stat_sel_o,
  output logic              stat_wr_o,
  output logic [REG_W-1:0]  reg_off_o
);
  logic            hit;
  iodec_tgt_e      tgt;
  logic [N_CH-1:0] ch_sel_d;

  iodec_base_match #(.HI_W(SW_W)) u_match (
    .addr_hi_i (addr_i[ADDR_W-1:LOW_W]),
    .sw_i      (sw_i),
    .hit_o     (hit)
  );

  iodec_target #(.REG_W(REG_W)) u_tgt (
    .hit_i     (hit),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .stat_en_i (stat_en_i),
    .off_i     (addr_i[REG_W-1:0]),
    .tgt_o     (tgt)
  );

  iodec_onehot #(.IDX_W(CH_W)) u_onehot (
    .idx_i (addr_i[LOW_W-1:REG_W]),
    .en_i  (tgt == TGT_CHAN),
    .sel_o (ch_sel_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_sel_o   <= '0;
      stat_sel_o <= 1'b0;
      stat_wr_o  <= 1'b0;
      reg_off_o  <= '0;
    end else begin
      ch_sel_o   <= ch_sel_d;
      stat_sel_o <= (tgt == TGT_STAT);
      stat_wr_o  <= (tgt == TGT_STAT) && wr_i;
      reg_off_o  <= addr_i[REG_W-1:0];
    end
  end
endmodule

// File: rtl/ioport_decoder_chk.sv
module ioport_decoder_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned REG_W  = 3,
  localparam int unsigned LOW_W = CH_W + REG_W,
  localparam int unsigned SW_W  = ADDR_W - LOW_W,
  localparam int unsigned N_CH  = 1 << CH_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [SW_W-1:0]   sw_i,
  input logic              stat_en_i,
  input logic [N_CH-1:0]   ch_sel_o,
  input logic              stat_sel_o,
  input logic              stat_wr_o,
  input logic [REG_W-1:0]  reg_off_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R6
  one_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ch_sel_o, stat_sel_o}));

  // R6
  no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(rd_i || wr_i)) |-> ({ch_sel_o, stat_sel_o} == '0));

  // R1
  base_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && ($past(addr_i[ADDR_W-1:LOW_W]) != ~$past(sw_i)))
      |-> ({ch_sel_o, stat_sel_o} == '0));

  // R5
  mode_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(stat_en_i)) |-> !stat_sel_o);

  // R7
  stat_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_o |-> (stat_sel_o && $past(wr_i)));

  // R3
  reg_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (reg_off_o == $past(addr_i[REG_W-1:0])));

  // R4
  stat_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_sel_o |-> (reg_off_o == {REG_W{1'b1}}));
endmodule

bind ioport_decoder ioport_decoder_chk #(
  .ADDR_W (ADDR_W),
  .CH_W   (CH_W),
  .REG_W  (REG_W)
) u_chk (.*);

// File: tb/ioport_decoder_bench.sv
module ioport_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0, stat_en_i = 1'b0;
  logic [9:0]  sw_i = '0;
  logic [7:0]  ch_sel_o;
  logic        stat_sel_o, stat_wr_o;
  logic [2:0]  reg_off_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  ioport_decoder u_ioport_decoder (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h sw=%h en=%0b rd=%0b wr=%0b act=%h exp=%h",
               tag, addr_i, sw_i, stat_en_i, rd_i, wr_i, act, exp);
    end
  endtask

  // drive at negedge, outputs settle after next posedge, sample at following negedge (R9)
  task automatic access(input logic [15:0] a, input logic r, input logic w,
                        input logic en, input logic [9:0] sw);
    logic hit, stb, is_stat;
    logic [7:0] e_ch;
    logic e_st, e_wr;
    string tag;
    addr_i = a; rd_i = r; wr_i = w; stat_en_i = en; sw_i = sw;
    hit = (a >> 6) == {6'd0, ~sw};
    stb = r | w;
    is_stat = en && (a[2:0] == 3'd7);
    e_st = hit && stb && is_stat;
    e_ch = (hit && stb && !is_stat) ? (8'd1 << a[5:3]) : 8'd0;
    e_wr = e_st && w;
    if (!hit)                  tag = "R1";
    else if (!stb)             tag = "R6";
    else if (is_stat)          tag = "R4";
    else if (a[2:0] == 3'd7)   tag = "R5";
    else                       tag = "R2";
    @(negedge clk_i);
    chk({tag, " R9 ch_sel"}, {8'd0, ch_sel_o}, {8'd0, e_ch});
    chk({tag, " stat_sel"}, {15'd0, stat_sel_o}, {15'd0, e_st});
    chk("R7 stat_wr", {15'd0, stat_wr_o}, {15'd0, e_wr});
    chk("R3 reg_off", {13'd0, reg_off_o}, {13'd0, a[2:0]});
  endtask

  initial begin
    automatic logic [9:0] sws [4] = '{10'h3F3, 10'h000, 10'h3FF, 10'h296};
    addr_i = 16'h0300; rd_i = 1'b1; wr_i = 1'b1; stat_en_i = 1'b1; sw_i = 10'h3F3;
    repeat (3) @(negedge clk_i);
    // R8: outputs held at 0 during reset despite matching access
    chk("R8 ch_sel", {8'd0, ch_sel_o}, 16'd0);
    chk("R8 stat_sel", {15'd0, stat_sel_o}, 16'd0);
    chk("R8 stat_wr", {15'd0, stat_wr_o}, 16'd0);
    chk("R8 reg_off", {13'd0, reg_off_o}, 16'd0);
    rst_ni = 1'b1;
    foreach (sws[s]) begin
      logic [15:0] base;
      base = {~sws[s], 6'd0};
      for (int en = 0; en < 2; en++)
        for (int st = 0; st < 4; st++)
          for (int o = 0; o < 64; o++)
            access(base + 16'(o), st[0], st[1], en[0], sws[s]);
      // near misses: flip each upper address bit at offset 7 and offset 0
      for (int b = 6; b < 16; b++)
        for (int en = 0; en < 2; en++) begin
          access((base | 16'd7) ^ (16'd1 << b), 1'b1, 1'b0, en[0], sws[s]);
          access((base | 16'd56) ^ (16'd1 << b), 1'b0, 1'b1, en[0], sws[s]);
        end
      // just outside the window
      access(base - 16'd1, 1'b1, 1'b0, 1'b1, sws[s]);
      access(base + 16'd64, 1'b0, 1'b1, 1'b1, sws[s]);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule